// File: doc/BRIEF.md
# Delay-Slot Register Dependence Classifier

This block looks at the instruction that sits in the delay slot of a pending register load and says how that instruction touches the load's destination register. The four answers are: it does not touch it, it only reads it, it only writes it, or it both reads and writes it. A pipeline controller uses the answer to decide whether the delay-slot instruction sees the register's old contents or the newly loaded value. It also uses the answer to decide which value survives once both have finished.

Each opcode family has a fixed rule that decides between a read match and a write match. A few families break the general pattern on purpose. Conditional branches never report a dependence. Unaligned partial-word loads let a write match win over a read match. The all-zero word is always treated as having no dependence.

The decision is made combinationally from the register number and the instruction word. It is captured in an output register on the clock edge where the input is marked valid. A valid flag travels alongside it with the same one-cycle latency.

Top module: `dsd_classifier`

## Requirements
- R1: Each input accepted with `in_valid` high shows its class on `dep_code` after exactly one rising clock edge, and `out_valid` is high in that cycle. The classes are encoded as 0 = none, 1 = read and written, 2 = read only, 3 = written only. The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. The special opcode is 0x00.
- R2: While reset is held, `out_valid` is 0 and `dep_code` is 0.
- R3: The all-zero instruction word always gives 0, even for register 0. A non-zero word that names register 0 is classified normally.
- R4: Shifts by constant (function 0x00, 0x02, 0x03) use rd as the written field and rt as the read field. Variable shifts (0x04, 0x06, 0x07), three-register arithmetic and logic (0x20–0x27, 0x2A, 0x2B) and jump-and-link-register (0x09) use rd as the written field and rs or rt as the read field. In all of these, a hit on both sides gives 1, a read hit gives 2 and a write hit gives 3.
- R5: Within the special opcode, the following give 2: jump-register (0x09's sibling 0x08) on an rs hit, move-to-HI/LO (0x11, 0x13) on an rs hit, and multiply/divide (0x18–0x1B) on an rs or rt hit. Move-from-HI/LO (0x10, 0x12) gives 3 on an rd hit. Other fields are ignored for these functions.
- R6: Opcodes 0x01 and 0x04–0x07 (conditional branches) give 0 whatever their register fields hold.
- R7: Opcode 0x03 (jump and link) gives 3 when the load register equals the link register (31 by default), and 0 otherwise. Opcode 0x0F (load upper immediate) gives 3 on an rt hit.
- R8: Immediate arithmetic (opcodes 0x08–0x0E) and the aligned loads 0x20, 0x21, 0x23, 0x24, 0x25 use rt as the written field and rs as the read field. Both hit gives 1, rs alone gives 2, rt alone gives 3.
- R9: Opcodes 0x22 and 0x26 give 3 on an rt hit, whether or not rs also hits. They give 2 on an rs hit alone.
- R10: Stores (opcodes 0x28, 0x29, 0x2A, 0x2B, 0x2E) give 2 on an rs or rt hit. Opcodes 0x32 and 0x3A give 2 on an rs hit only.
- R11: Opcode 0x12 with function 0 is selected by its rs field. Values 0 and 2 give 3 on an rt hit, and values 4 and 6 give 2 on an rt hit. Any other rs value, or any non-zero function, gives 0.
- R12: Every opcode or special-function code not named above gives 0.
- R13: A cycle with `in_valid` low leaves `dep_code` unchanged and drives `out_valid` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Marks `load_reg` and `slot_insn` as a request |
| load_reg | input | 5 | Destination register number of the pending load |
| slot_insn | input | 32 | Instruction word in the load's delay slot |
| out_valid | output | 1 | Registered copy of `in_valid` |
| dep_code | output | 2 | Registered dependence class |

## Verification
The bench targets the points where one family's rule differs from its neighbour's. An implementation that reused the generic rule for the unaligned loads would report 1 instead of 3 when rt and rs both match. Decoding branches like other readers would report 2 for a branch comparing the loaded register. Forgetting the all-zero exemption would report 1 for register 0, and only a non-zero word naming register 0 tells that case apart from a correct design. The coprocessor move group checks that a non-zero function or an unlisted rs selector clears the result; a decoder that looked only at rs would return 3 or 2 there. The bench also checks that an idle cycle keeps the previous code, so a design that reloaded the register without `in_valid` would show the class of the ignored word.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   localparam int INSN_W = 32;
   localparam int REG_W  = 5;
   localparam int OPC_W  = 6;
   localparam int FN_W   = 6;

   // field positions inside the instruction word
   localparam int OPC_LSB = INSN_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_W;
   localparam int RT_LSB  = RS_LSB - REG_W;
   localparam int RD_LSB  = RT_LSB - REG_W;

   typedef enum logic [1:0] {
      DEP_NONE  = 2'd0,
      DEP_BOTH  = 2'd1,
      DEP_READ  = 2'd2,
      DEP_WRITE = 2'd3
   } dep_e;

   // primary opcodes
   localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
   localparam logic [OPC_W-1:0] OP_REGIMM  = 6'h01;
   localparam logic [OPC_W-1:0] OP_JLINK   = 6'h03;
   localparam logic [OPC_W-1:0] OP_BEQ     = 6'h04;
   localparam logic [OPC_W-1:0] OP_BNE     = 6'h05;
   localparam logic [OPC_W-1:0] OP_BLEZ    = 6'h06;
   localparam logic [OPC_W-1:0] OP_BGTZ    = 6'h07;
   localparam logic [OPC_W-1:0] OP_UPPER   = 6'h0F;
   localparam logic [OPC_W-1:0] OP_COPV    = 6'h12;
   localparam logic [OPC_W-1:0] OP_LDL     = 6'h22;
   localparam logic [OPC_W-1:0] OP_LDR     = 6'h26;
   localparam logic [OPC_W-1:0] OP_CLD     = 6'h32;
   localparam logic [OPC_W-1:0] OP_CST     = 6'h3A;

   typedef struct packed {
      logic [OPC_W-1:0] opc;
      logic [REG_W-1:0] rs;
      logic [FN_W-1:0]  fn;
      logic             is_nop;
      logic             hit_rs;
      logic             hit_rt;
      logic             hit_rd;
      logic             hit_link;
   } slot_t;

   typedef struct packed {
      logic rd_use;
      logic wr_use;
   } use_t;

endpackage

// File: rtl/dsd_fields.sv
module dsd_fields
   import dsd_pkg::*;
#(
   parameter int LINK_REG = 31
) (
   input  logic [REG_W-1:0]  load_reg,
   input  logic [INSN_W-1:0] slot_insn,
   output slot_t             fld
);

   localparam logic [REG_W-1:0] LINK_ID = REG_W'(LINK_REG);

   logic [REG_W-1:0] rt_f;
   logic [REG_W-1:0] rd_f;
   logic [RD_LSB-FN_W-1:0] unused_shamt;

   assign rt_f         = slot_insn[RT_LSB +: REG_W];
   assign rd_f         = slot_insn[RD_LSB +: REG_W];
   assign unused_shamt = slot_insn[RD_LSB-1:FN_W];

   always_comb begin
      fld          = '0;
      fld.opc      = slot_insn[OPC_LSB +: OPC_W];
      fld.rs       = slot_insn[RS_LSB +: REG_W];
      fld.fn       = slot_insn[FN_W-1:0];
      fld.is_nop   = (slot_insn == '0);
      fld.hit_rs   = (fld.rs == load_reg);
      fld.hit_rt   = (rt_f == load_reg);
      fld.hit_rd   = (rd_f == load_reg);
      fld.hit_link = (load_reg == LINK_ID);
   end

endmodule

// File: rtl/dsd_rules.sv
module dsd_rules
   import dsd_pkg::*;
(
   input  slot_t fld,
   output use_t  usage
);

   // read/write mask for the special-opcode function space
   use_t spc;
   always_comb begin
      spc = '0;
      unique case (fld.fn)
         6'h00, 6'h02, 6'h03: begin
            spc.rd_use = fld.hit_rt;
            spc.wr_use = fld.hit_rd;
         end
         6'h04, 6'h06, 6'h07,
         6'h20, 6'h21, 6'h22, 6'h23,
         6'h24, 6'h25, 6'h26, 6'h27,
         6'h2A, 6'h2B: begin
            spc.rd_use = fld.hit_rs | fld.hit_rt;
            spc.wr_use = fld.hit_rd;
         end
         6'h08:        spc.rd_use = fld.hit_rs;
         6'h09: begin
            spc.rd_use = fld.hit_rs;
            spc.wr_use = fld.hit_rd;
         end
         6'h10, 6'h12: spc.wr_use = fld.hit_rd;
         6'h11, 6'h13: spc.rd_use = fld.hit_rs;
         6'h18, 6'h19, 6'h1A, 6'h1B:
                       spc.rd_use = fld.hit_rs | fld.hit_rt;
         default:      spc = '0;
      endcase
   end

   // read/write mask for the coprocessor move group
   use_t cop;
   always_comb begin
      cop = '0;
      if (fld.fn == '0) begin
         unique case (fld.rs)
            5'd0, 5'd2: cop.wr_use = fld.hit_rt;
            5'd4, 5'd6: cop.rd_use = fld.hit_rt;
            default:    cop = '0;
         endcase
      end
   end

   always_comb begin
      usage = '0;
      if (!fld.is_nop) begin
         unique case (fld.opc)
            OP_SPECIAL: usage = spc;
            OP_COPV:    usage = cop;
            OP_JLINK:   usage.wr_use = fld.hit_link;
            OP_UPPER:   usage.wr_use = fld.hit_rt;
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
               usage.rd_use = fld.hit_rs;
               usage.wr_use = fld.hit_rt;
            end
            OP_LDL, OP_LDR: begin
               // write match masks the read match
               usage.wr_use = fld.hit_rt;
               usage.rd_use = fld.hit_rs & ~fld.hit_rt;
            end
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
               usage.rd_use = fld.hit_rs | fld.hit_rt;
            OP_CLD, OP_CST:
               usage.rd_use = fld.hit_rs;
            // branches and every unlisted opcode report nothing
            default: usage = '0;
         endcase
      end
   end

endmodule

// File: rtl/dsd_stage.sv
module dsd_stage
   import dsd_pkg::*;
#(
   parameter int ASYNC_RESET = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  use_t       usage,
   output logic       out_valid,
   output logic [1:0] dep_code
);

   dep_e code_d;

   always_comb begin
      unique case ({usage.rd_use, usage.wr_use})
         2'b11:   code_d = DEP_BOTH;
         2'b10:   code_d = DEP_READ;
         2'b01:   code_d = DEP_WRITE;
         default: code_d = DEP_NONE;
      endcase
   end

   generate
      if (ASYNC_RESET != 0) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               dep_code  <= DEP_NONE;
            end else begin
               out_valid <= in_valid;
               if (in_valid) dep_code <= code_d;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               dep_code  <= DEP_NONE;
            end else begin
               out_valid <= in_valid;
               if (in_valid) dep_code <= code_d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dsd_classifier.sv
module dsd_classifier
   import dsd_pkg::*;
#(
   parameter int LINK_REG    = 31,
   parameter int ASYNC_RESET = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [4:0]  load_reg,
   input  logic [31:0] slot_insn,
   output logic        out_valid,
   output logic [1:0]  dep_code
);

   generate
      if (LINK_REG < 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("LINK_REG must name a register in the file");
      end
      if (ASYNC_RESET != 0 && ASYNC_RESET != 1) begin : g_bad_rst
         $error("ASYNC_RESET must be 0 or 1");
      end
      if (INSN_W != OPC_W + 3 * REG_W + 5 + FN_W) begin : g_bad_fmt
         $error("instruction field widths do not fill the word");
      end
   endgenerate

   slot_t fld;
   use_t  usage;

   dsd_fields #(.LINK_REG(LINK_REG)) u_fields (
      .load_reg  (load_reg),
      .slot_insn (slot_insn),
      .fld       (fld)
   );

   dsd_rules u_rules (
      .fld   (fld),
      .usage (usage)
   );

   dsd_stage #(.ASYNC_RESET(ASYNC_RESET)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .usage     (usage),
      .out_valid (out_valid),
      .dep_code  (dep_code)
   );

endmodule

// File: rtl/dsd_classifier_chk.sv
module dsd_classifier_chk #(
   parameter int LINK_REG = 31
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [4:0]  load_reg,
   input logic [31:0] slot_insn,
   input logic        out_valid,
   input logic [1:0]  dep_code
);

   logic [5:0] opc;
   logic [4:0] rt_f;
   assign opc  = slot_insn[31:26];
   assign rt_f = slot_insn[20:16];

   p_reset_clear_r2: assert property (@(posedge clk)
      !rst_n |=> (dep_code == 2'd0 && !out_valid));

   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(dep_code));

   p_nop_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && slot_insn == 32'h0) |=> dep_code == 2'd0);

   p_branch_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opc == 6'h01 || (opc >= 6'h04 && opc <= 6'h07)))
      |=> dep_code == 2'd0);

   p_link_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc == 6'h03)
      |=> dep_code == (($past(load_reg) == 5'(LINK_REG)) ? 2'd3 : 2'd0));

   p_unaligned_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opc == 6'h22 || opc == 6'h26) && rt_f == load_reg)
      |=> dep_code == 2'd3);

   p_store_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opc == 6'h28 || opc == 6'h29 || opc == 6'h2A ||
                    opc == 6'h2B || opc == 6'h2E))
      |=> (dep_code == 2'd0 || dep_code == 2'd2));

endmodule

bind dsd_classifier dsd_classifier_chk #(.LINK_REG(LINK_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .load_reg  (load_reg),
   .slot_insn (slot_insn),
   .out_valid (out_valid),
   .dep_code  (dep_code)
);

// File: tb/dsd_classifier_test.sv
`timescale 1ns/100ps
module dsd_classifier_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  load_reg = '0;
   logic [31:0] slot_insn = '0;
   logic        out_valid;
   logic [1:0]  dep_code;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dsd_classifier uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .load_reg  (load_reg),
      .slot_insn (slot_insn),
      .out_valid (out_valid),
      .dep_code  (dep_code)
   );

   function automatic logic [31:0] rw(int op, int rs, int rt, int rd, int fn);
      logic [31:0] w;
      w = {op[5:0], rs[4:0], rt[4:0], rd[4:0], 5'd1, fn[5:0]};
      return w;
   endfunction

   function automatic logic [31:0] iw(int op, int rs, int rt);
      logic [31:0] w;
      w = {op[5:0], rs[4:0], rt[4:0], 16'h1234};
      return w;
   endfunction

   typedef struct packed {
      logic [7:0]  req;
      logic [4:0]  lreg;
      logic [31:0] insn;
      logic [1:0]  exp;
   } vec_t;

   localparam int NV = 63;
   localparam vec_t VEC [NV] = '{
      // R3: all-zero word, and a non-zero word naming register 0
      '{8'd3, 5'd0,  32'h0, 2'd0},
      '{8'd3, 5'd8,  32'h0, 2'd0},
      '{8'd3, 5'd0,  rw(0, 0, 0, 0, 'h21), 2'd1},
      // R4: shifts, three-register ops, jump-and-link-register
      '{8'd4, 5'd8,  rw(0, 0, 8, 8, 'h00), 2'd1},
      '{8'd4, 5'd8,  rw(0, 0, 8, 3, 'h02), 2'd2},
      '{8'd4, 5'd8,  rw(0, 0, 3, 8, 'h03), 2'd3},
      '{8'd4, 5'd8,  rw(0, 8, 2, 8, 'h21), 2'd1},
      '{8'd4, 5'd8,  rw(0, 2, 8, 4, 'h25), 2'd2},
      '{8'd4, 5'd8,  rw(0, 1, 2, 8, 'h2A), 2'd3},
      '{8'd4, 5'd8,  rw(0, 8, 1, 5, 'h04), 2'd2},
      '{8'd4, 5'd8,  rw(0, 1, 2, 8, 'h07), 2'd3},
      '{8'd4, 5'd8,  rw(0, 8, 0, 8, 'h09), 2'd1},
      '{8'd4, 5'd8,  rw(0, 8, 0, 31, 'h09), 2'd2},
      '{8'd4, 5'd8,  rw(0, 4, 0, 8, 'h09), 2'd3},
      // R5: jump-register, HI/LO moves, multiply/divide
      '{8'd5, 5'd8,  rw(0, 8, 0, 0, 'h08), 2'd2},
      '{8'd5, 5'd8,  rw(0, 1, 8, 0, 'h08), 2'd0},
      '{8'd5, 5'd8,  rw(0, 0, 0, 8, 'h10), 2'd3},
      '{8'd5, 5'd8,  rw(0, 8, 0, 7, 'h12), 2'd0},
      '{8'd5, 5'd8,  rw(0, 8, 0, 0, 'h13), 2'd2},
      '{8'd5, 5'd8,  rw(0, 1, 0, 8, 'h11), 2'd0},
      '{8'd5, 5'd8,  rw(0, 1, 8, 0, 'h19), 2'd2},
      '{8'd5, 5'd8,  rw(0, 8, 1, 0, 'h1A), 2'd2},
      // R6: conditional branches stay silent
      '{8'd6, 5'd8,  iw('h04, 8, 8), 2'd0},
      '{8'd6, 5'd8,  iw('h05, 8, 3), 2'd0},
      '{8'd6, 5'd8,  iw('h06, 8, 0), 2'd0},
      '{8'd6, 5'd8,  iw('h07, 8, 0), 2'd0},
      '{8'd6, 5'd8,  iw('h01, 8, 'h11), 2'd0},
      '{8'd6, 5'd8,  iw('h01, 8, 0), 2'd0},
      // R7: jump-and-link and load upper
      '{8'd7, 5'd31, iw('h03, 0, 0), 2'd3},
      '{8'd7, 5'd8,  iw('h03, 8, 8), 2'd0},
      '{8'd7, 5'd8,  iw('h0F, 0, 8), 2'd3},
      '{8'd7, 5'd8,  iw('h0F, 8, 1), 2'd0},
      // R8: immediate arithmetic and aligned loads
      '{8'd8, 5'd8,  iw('h09, 8, 8), 2'd1},
      '{8'd8, 5'd8,  iw('h0D, 8, 2), 2'd2},
      '{8'd8, 5'd8,  iw('h0A, 1, 8), 2'd3},
      '{8'd8, 5'd8,  iw('h0E, 8, 8), 2'd1},
      '{8'd8, 5'd8,  iw('h23, 8, 8), 2'd1},
      '{8'd8, 5'd8,  iw('h24, 8, 2), 2'd2},
      '{8'd8, 5'd8,  iw('h21, 1, 8), 2'd3},
      '{8'd8, 5'd8,  iw('h20, 8, 8), 2'd1},
      // R9: unaligned loads, write wins
      '{8'd9, 5'd8,  iw('h22, 8, 8), 2'd3},
      '{8'd9, 5'd8,  iw('h26, 8, 1), 2'd2},
      '{8'd9, 5'd8,  iw('h22, 2, 8), 2'd3},
      '{8'd9, 5'd8,  iw('h26, 8, 8), 2'd3},
      // R10: stores and coprocessor load/store
      '{8'd10, 5'd8, iw('h2B, 1, 8), 2'd2},
      '{8'd10, 5'd8, iw('h28, 8, 1), 2'd2},
      '{8'd10, 5'd8, iw('h2E, 8, 8), 2'd2},
      '{8'd10, 5'd8, iw('h2A, 8, 8), 2'd2},
      '{8'd10, 5'd8, iw('h3A, 8, 1), 2'd2},
      '{8'd10, 5'd8, iw('h32, 8, 1), 2'd2},
      '{8'd10, 5'd8, iw('h32, 1, 8), 2'd0},
      // R12: unlisted codes
      '{8'd12, 5'd8, rw(0, 8, 8, 8, 'h0C), 2'd0},
      '{8'd12, 5'd8, rw(0, 0, 0, 8, 'h05), 2'd0},
      '{8'd12, 5'd8, iw('h10, 8, 8), 2'd0},
      '{8'd12, 5'd8, iw('h3F, 8, 8), 2'd0},
      '{8'd12, 5'd8, iw('h02, 8, 8), 2'd0},
      // R11: coprocessor moves selected by rs
      '{8'd11, 5'd8, {6'h12, 5'd0, 5'd8, 16'h0}, 2'd3},
      '{8'd11, 5'd8, {6'h12, 5'd2, 5'd8, 16'h0}, 2'd3},
      '{8'd11, 5'd8, {6'h12, 5'd4, 5'd8, 16'h1}, 2'd0},
      '{8'd11, 5'd8, {6'h12, 5'd1, 5'd8, 16'h0}, 2'd0},
      '{8'd11, 5'd8, {6'h12, 5'd0, 5'd3, 16'h0}, 2'd0},
      '{8'd11, 5'd8, {6'h12, 5'd4, 5'd8, 16'h0}, 2'd2},
      '{8'd11, 5'd8, {6'h12, 5'd6, 5'd8, 16'h0}, 2'd2}
   };

   task automatic check(int req, logic [1:0] got, logic [1:0] exp, string what);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   initial begin
      // R2: reset state
      repeat (3) @(negedge clk);
      check(2, dep_code, 2'd0, "code under reset");
      check(2, {1'b0, out_valid}, 2'd0, "valid under reset");
      rst_n = 1'b1;
      @(negedge clk);

      // streamed table, one vector per cycle
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check(int'(VEC[i-1].req), dep_code, VEC[i-1].exp, $sformatf("vector %0d", i - 1));
            check(1, {1'b0, out_valid}, 2'd1, "valid while streaming"); // R1
         end
         if (i < NV) begin
            in_valid  = 1'b1;
            load_reg  = VEC[i].lreg;
            slot_insn = VEC[i].insn;
         end else begin
            in_valid = 1'b0;
         end
      end

      // R13: idle cycle with a word that would classify as 3
      load_reg  = 5'd8;
      slot_insn = iw('h0F, 0, 8);
      @(negedge clk);
      check(13, dep_code, 2'd2, "code held while idle");
      check(13, {1'b0, out_valid}, 2'd0, "valid low while idle");

      // R1: single request, one-edge latency
      in_valid  = 1'b1;
      load_reg  = 5'd31;
      slot_insn = iw('h03, 0, 0);
      @(negedge clk);
      check(1, dep_code, 2'd3, "single request result");
      check(1, {1'b0, out_valid}, 2'd1, "single request valid");
      in_valid  = 1'b0;
      load_reg  = 5'd0;
      slot_insn = 32'h0;
      @(negedge clk);
      check(13, dep_code, 2'd3, "code held after request");
      check(1, {1'b0, out_valid}, 2'd0, "valid drops after request");

      // R2: reset in mid-run clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check(2, dep_code, 2'd0, "code after mid-run reset");
      check(2, {1'b0, out_valid}, 2'd0, "valid after mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #50000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule